// File: doc/BRIEF.md
# Interrupt Message Flush Handshake

This block stands between an interrupt message sender and the rest of the system. Before any interrupt message may leave, the posted-write buffers along the path to memory have to be emptied. The block does this by asking for it and then waiting for the answers. When the sender raises `msg_ready`, the block drives its active-low request pin low. It then waits until two separate agents have both pulled their active-low acknowledge pins low. Only then does it raise `grant`, which lets the sender transmit.

When the sender pulses `msg_done`, the block lets go of the request. It will not start another request until the acknowledges have been seen released. Each acknowledge passes through a two-flop synchronizer clocked by the bus-rate clock. The request pin has its own output enable, and that enable is off while reset is applied, so the pin floats to its pulled-up inactive level.

Some systems have no second agent, and there its acknowledge pin is strapped low for good. The parameter `ACK_B_TIED` tells the block about this. When it is set, the block takes the second acknowledge as always present, and release then depends on the first acknowledge alone.

Top module: `irq_flush_handshake`

## Requirements
- R1: While `rst` is high, `req_oe` is 0, `req_n` is 1 and `grant` is 0.
- R2: In the idle state, with both acknowledges seen released, a high `msg_ready` drives `req_n` low after the next clock edge.
- R3: While a request is pending, `grant` stays 0 if only the first acknowledge is asserted, if only the second is asserted, or if neither is. Losing one acknowledge before both are present together keeps the block waiting.
- R4: Both acknowledges must be low (asserted) before a clock edge. `grant` then rises on the third clock edge after that: two edges for synchronization and one for the state change.
- R5: Once high, `grant` stays high until `msg_done` is seen, even if the acknowledges drop. A `msg_done` during grant clears `grant` and returns `req_n` to 1 after the next edge.
- R6: After release, no new request starts while either acknowledge is still seen asserted. With `msg_ready` held high, `req_n` goes low on the fourth edge after the last acknowledge goes high.
- R7: With `ACK_B_TIED`=1, the second acknowledge pin is ignored. `grant` follows the first acknowledge alone with the same three-edge latency, and a new request waits only for the first acknowledge to be released.
- R8: `req_oe` becomes 1 on the first clock edge after `rst` falls.
- R9: A `msg_done` pulse while the request is still waiting for acknowledges has no effect: `req_n` stays 0 and `grant` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-rate clock; all handshake signals are sampled on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| msg_ready | input | 1 | Sender has a message waiting (level) |
| msg_done | input | 1 | Sender finished transmitting (one-cycle pulse) |
| ack_a_n | input | 1 | First acknowledge, active low, asynchronous |
| ack_b_n | input | 1 | Second acknowledge, active low, asynchronous; may be strapped low |
| req_n | output | 1 | Request value, active low |
| req_oe | output | 1 | Output enable for the request pin; 0 during reset |
| grant | output | 1 | Permission for the sender to transmit |

## Verification
The pending request is held while every acknowledge pair short of both-asserted is applied, one after another. This shows whether the block waits for the two acknowledges together or wrongly accepts either one alone, or the last one seen. The cycle on which `grant` rises after both acknowledges arrive, and the cycle on which a held `msg_ready` turns into a new request after release, are checked to the exact edge; these catch a missing or extra synchronizer stage. Dropping the acknowledges during grant, and pulsing `msg_done` while the request is still waiting, test what should stay fixed. A second instance with the strapped option repeats the cycle with one live acknowledge.

// File: rtl/irq_hs_pkg.sv
package irq_hs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_GRANT = 2'd2,
    HS_DRAIN = 2'd3
  } hs_state_e;

  // Both acknowledges present (second may be forced by strap).
  function automatic logic hs_acks_met(input logic a_seen, input logic b_seen,
                                       input logic b_tied);
    return a_seen & (b_tied | b_seen);
  endfunction

  // Acknowledges released; a strapped second acknowledge does not count.
  function automatic logic hs_acks_clear(input logic a_seen, input logic b_seen,
                                         input logic b_tied);
    return ~a_seen & (b_tied | ~b_seen);
  endfunction

endpackage

// File: rtl/irq_ack_sync.sv
module irq_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic seen
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], pin_n};
  end

  assign seen = ~chain[LAST];
endmodule

// File: rtl/irq_hs_fsm.sv
module irq_hs_fsm
  import irq_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      finish,
  input  logic      acks_met,
  input  logic      acks_clear,
  output hs_state_e state,
  output logic      req_active,
  output logic      grant
);
  hs_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      HS_IDLE:  if (start && acks_clear) nxt = HS_REQ;
      HS_REQ:   if (acks_met)            nxt = HS_GRANT;
      HS_GRANT: if (finish)              nxt = HS_DRAIN;
      HS_DRAIN: if (acks_clear)          nxt = HS_IDLE;
      default:                           nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= HS_IDLE;
    else     state <= nxt;
  end

  assign req_active = (state == HS_REQ) || (state == HS_GRANT);
  assign grant      = (state == HS_GRANT);
endmodule

// File: rtl/irq_flush_handshake.sv
module irq_flush_handshake
  import irq_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit ACK_B_TIED  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic msg_ready,
  input  logic msg_done,
  input  logic ack_a_n,
  input  logic ack_b_n,
  output logic req_n,
  output logic req_oe,
  output logic grant
);
  localparam int NUM_ACKS = 2;

  logic [NUM_ACKS-1:0] ack_pins_n;
  logic [NUM_ACKS-1:0] ack_seen;
  logic      ack_a_seen;
  logic      ack_b_eff;
  logic      acks_ok;
  logic      acks_gone;
  logic      req_active;
  hs_state_e hs_state;

  assign ack_pins_n = {ack_b_n, ack_a_n};

  for (genvar g = 0; g < NUM_ACKS; g++) begin : g_sync
    irq_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin_n(ack_pins_n[g]),
      .seen (ack_seen[g])
    );
  end

  assign ack_a_seen = ack_seen[0];
  assign ack_b_eff  = ACK_B_TIED ? 1'b1 : ack_seen[1];
  assign acks_ok    = hs_acks_met(ack_a_seen, ack_seen[1], ACK_B_TIED);
  assign acks_gone  = hs_acks_clear(ack_a_seen, ack_seen[1], ACK_B_TIED);

  irq_hs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (msg_ready),
    .finish    (msg_done),
    .acks_met  (acks_ok),
    .acks_clear(acks_gone),
    .state     (hs_state),
    .req_active(req_active),
    .grant     (grant)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) req_oe <= 1'b0;
    else     req_oe <= 1'b1;
  end

  assign req_n = ~req_active;
endmodule

// File: rtl/irq_hs_checker.sv
module irq_hs_checker
  import irq_hs_pkg::*;
#(
  parameter bit ACK_B_TIED = 1'b0
) (
  input logic      clk,
  input logic      rst,
  input logic      msg_ready,
  input logic      msg_done,
  input logic      req_n,
  input logic      req_oe,
  input logic      grant,
  input logic      ack_a_seen,
  input logic      ack_b_eff,
  input logic      acks_gone,
  input hs_state_e hs_state
);
  always @(negedge clk) begin
    if (rst) begin
      assert_reset_quiet_R1: assert (!req_oe && req_n && !grant);
    end
  end

  assert_req_start_R2: assert property (@(posedge clk) disable iff (rst)
    (hs_state == HS_IDLE && msg_ready && acks_gone) |=> !req_n);

  assert_grant_needs_both_R3: assert property (@(posedge clk) disable iff (rst)
    (hs_state == HS_REQ && !(ack_a_seen && ack_b_eff)) |=> !grant);

  assert_grant_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (grant && !msg_done) |=> grant);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (rst)
    (grant && msg_done) |=> (req_n && !grant));

  assert_drain_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (hs_state == HS_DRAIN && !acks_gone) |=> req_n);

  assert_oe_on_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> req_oe);

  assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (hs_state == HS_REQ && !(ack_a_seen && ack_b_eff) && msg_done) |=> (!req_n && !grant));

  if (ACK_B_TIED) begin : g_tied
    assert_tied_grant_R7: assert property (@(posedge clk) disable iff (rst)
      (hs_state == HS_REQ && ack_a_seen) |=> grant);
  end
endmodule

bind irq_flush_handshake irq_hs_checker #(.ACK_B_TIED(ACK_B_TIED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_ready (msg_ready),
  .msg_done  (msg_done),
  .req_n     (req_n),
  .req_oe    (req_oe),
  .grant     (grant),
  .ack_a_seen(ack_a_seen),
  .ack_b_eff (ack_b_eff),
  .acks_gone (acks_gone),
  .hs_state  (hs_state)
);

// File: tb/irq_flush_handshake_tb.sv
module irq_flush_handshake_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_ready = 1'b0, msg_done = 1'b0, ack_a_n = 1'b1, ack_b_n = 1'b1;
  logic t_ready = 1'b0, t_done = 1'b0, t_ack_a_n = 1'b1;
  logic req_n, req_oe, grant;
  logic t_req_n, t_req_oe, t_grant;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  irq_flush_handshake u_dut (
    .clk(clk), .rst(rst), .msg_ready(msg_ready), .msg_done(msg_done),
    .ack_a_n(ack_a_n), .ack_b_n(ack_b_n),
    .req_n(req_n), .req_oe(req_oe), .grant(grant)
  );

  irq_flush_handshake #(.ACK_B_TIED(1'b1)) u_dut_tied (
    .clk(clk), .rst(rst), .msg_ready(t_ready), .msg_done(t_done),
    .ack_a_n(t_ack_a_n), .ack_b_n(1'b0),
    .req_n(t_req_n), .req_oe(t_req_oe), .grant(t_grant)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // Expected grant from the requirement: grant only when both are asserted.
  function automatic logic both_asserted(input logic a_n, input logic b_n);
    return (a_n == 1'b0) && (b_n == 1'b0);
  endfunction

  initial begin
    step(2);
    check(req_oe, 1'b0, "R1 req_oe in reset");
    check(req_n,  1'b1, "R1 req_n in reset");
    check(grant,  1'b0, "R1 grant in reset");
    check(t_req_oe, 1'b0, "R1 tied req_oe in reset");
    rst = 1'b0;
    step(1);
    check(req_oe, 1'b1, "R8 req_oe after reset");
    check(t_req_oe, 1'b1, "R8 tied req_oe after reset");

    msg_ready = 1'b1;
    step(1);
    check(req_n, 1'b0, "R2 request asserted");
    msg_ready = 1'b0;

    // R3 sweep of partial acknowledge pairs, in an order that also drops one ack
    for (int k = 0; k < 4; k++) begin
      logic [1:0] pat;
      pat = (k == 0) ? 2'b10 : (k == 1) ? 2'b01 : (k == 2) ? 2'b11 : 2'b10;
      ack_a_n = pat[0];
      ack_b_n = pat[1];
      step(4);
      check(grant, both_asserted(ack_a_n, ack_b_n), "R3 partial acks no grant");
      check(req_n, 1'b0, "R3 request held while waiting");
    end

    ack_a_n = 1'b0; ack_b_n = 1'b0;
    step(2);
    check(grant, 1'b0, "R4 grant not before third edge");
    step(1);
    check(grant, 1'b1, "R4 grant on third edge");

    ack_a_n = 1'b1;
    step(5);
    check(grant, 1'b1, "R5 grant held without done");
    msg_done = 1'b1;
    step(1);
    msg_done = 1'b0;
    check(grant, 1'b0, "R5 grant cleared by done");
    check(req_n, 1'b1, "R5 request released by done");

    msg_ready = 1'b1;
    step(6);
    check(req_n, 1'b1, "R6 no request while ack b held");
    ack_b_n = 1'b1;
    step(3);
    check(req_n, 1'b1, "R6 no request before fourth edge");
    step(1);
    check(req_n, 1'b0, "R6 request on fourth edge");
    msg_ready = 1'b0;

    msg_done = 1'b1;
    step(1);
    msg_done = 1'b0;
    step(3);
    check(req_n, 1'b0, "R9 done ignored while waiting");
    check(grant, 1'b0, "R9 no grant after stray done");

    ack_a_n = 1'b0; ack_b_n = 1'b0;
    step(3);
    check(grant, 1'b1, "R4 second grant");
    msg_done = 1'b1;
    step(1);
    msg_done = 1'b0;
    ack_a_n = 1'b1; ack_b_n = 1'b1;
    step(4);
    check(req_n, 1'b1, "R5 idle after cycle");

    // R7 strapped second acknowledge
    t_ready = 1'b1;
    step(1);
    check(t_req_n, 1'b0, "R7 tied request asserted");
    t_ready = 1'b0;
    step(4);
    check(t_grant, 1'b0, "R7 tied waits for ack a");
    t_ack_a_n = 1'b0;
    step(2);
    check(t_grant, 1'b0, "R7 tied grant not before third edge");
    step(1);
    check(t_grant, 1'b1, "R7 tied grant on ack a alone");
    t_done = 1'b1;
    step(1);
    t_done = 1'b0;
    check(t_grant, 1'b0, "R7 tied grant cleared");
    t_ready = 1'b1;
    step(4);
    check(t_req_n, 1'b1, "R7 tied no request while ack a held");
    t_ack_a_n = 1'b1;
    step(3);
    check(t_req_n, 1'b1, "R7 tied no request before fourth edge");
    step(1);
    check(t_req_n, 1'b0, "R7 tied request after ack a release");
    t_ready = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule